// File: doc/BRIEF.md
# Vectored Interrupt and Restart Unit

This unit sits beside the instruction decoder and turns restart requests and hardware interrupt lines into 16-bit vector addresses. A software restart carries a 3-bit number `n`, and the unit loads the vector `n * 8`. Four hardware lines are also watched:

- a non-maskable trap;
- three maskable lines, called line A, line B and line C, listed from lowest to highest priority.

Each maskable line has its own mask bit. The three lines also share one interrupt-enable flip-flop.

A hardware interrupt is accepted only at an instruction boundary, which the decoder signals with `boundary_i`, or at any cycle while the unit is halted. On acceptance the unit raises `take_o` for one cycle and loads the matching vector. Pushing the program counter is left to the stack sequencer, which acts on `take_o`. Acceptance also clears the enable flip-flop, so software must re-arm it with the enable strobe. A halt request parks the unit until an interrupt is taken or reset is applied.

Top module: `irq_unit`

## Requirements
- R1: A cycle with `sw_req_i` high and no hardware interrupt accepted loads `vector_o` with `sw_num_i * 8` at the next clock edge (0x0000 to 0x0038) and leaves `take_o` low.
- R2: The vectors of accepted hardware interrupts are 0x0024 for the trap, 0x002C for line A (`line_i[0]`), 0x0034 for line B (`line_i[1]`) and 0x003C for line C (`line_i[2]`).
- R3: When several lines qualify in the same cycle, the trap wins, then line C, then line B, then line A.
- R4: While the enable flip-flop is clear, the maskable lines are never accepted, but the trap still is.
- R5: `ie_set_i` sets the enable flip-flop. `ie_clr_i` clears it and wins over `ie_set_i` in the same cycle.
- R6: Reset clears the enable flip-flop, the mask bits, `take_o`, `halted_o` and `vector_o`. Every accepted interrupt clears the enable flip-flop, and this clear wins over a simultaneous `ie_set_i`.
- R7: `mask_load_i` loads `mask_i` into the mask bits: bit 0 masks line A, bit 1 masks line B, bit 2 masks line C. A set bit blocks its line. The trap has no mask bit.
- R8: An interrupt is accepted only in a cycle where `boundary_i` or `halted_o` is high and `take_o` is low. `take_o` rises at the following edge and lasts exactly one cycle.
- R9: `halt_req_i` sets `halted_o` at the next edge. An accepted interrupt clears it at the same edge that raises `take_o`, and this clear wins over a simultaneous `halt_req_i`. While `halted_o` is high, pending interrupts are accepted without `boundary_i`.
- R10: If a hardware interrupt is accepted in the same cycle as a software restart request, the hardware vector is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary strobe |
| sw_req_i | input | 1 | Software restart request |
| sw_num_i | input | 3 | Software restart number |
| ie_set_i | input | 1 | Enable strobe for the interrupt-enable flip-flop |
| ie_clr_i | input | 1 | Disable strobe for the interrupt-enable flip-flop |
| mask_load_i | input | 1 | Load strobe for the mask bits |
| mask_i | input | 3 | New mask bits (bit 0 line A, bit 1 line B, bit 2 line C) |
| halt_req_i | input | 1 | Halt request |
| trap_i | input | 1 | Non-maskable trap line |
| line_i | input | 3 | Maskable lines (bit 0 A, bit 1 B, bit 2 C) |
| take_o | output | 1 | One-cycle interrupt-taken pulse |
| vector_o | output | 16 | Vector address |
| halted_o | output | 1 | Halt state |

## Verification
The hardest situation to reach is several conditions landing in one cycle. Examples are acceptance together with an enable strobe, a halt request or a software restart, or a second boundary that arrives right after a take while the trap is still held. Directed steps set up each of these collisions on purpose. The rest is covered by a long run of seeded random stimulus. In that run the enable, mask and halt strobes have a high enough probability that masked, disabled and halted states keep meeting pending lines.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int NUM_LINES = 3;

  typedef enum logic [1:0] {
    SRC_TRAP = 2'd0,
    SRC_LA   = 2'd1,
    SRC_LB   = 2'd2,
    SRC_LC   = 2'd3
  } src_e;

  localparam logic [15:0] TRAP_VEC  = 16'h0024;
  localparam logic [15:0] LINE_BASE = 16'h002C;
  localparam logic [15:0] LINE_STEP = 16'h0008;

  function automatic logic [15:0] hw_vec(src_e s);
    if (s == SRC_TRAP) return TRAP_VEC;
    return LINE_BASE + LINE_STEP * 16'({14'd0, s} - 16'd1);
  endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_unit_pkg::*;
#(
  parameter int N = NUM_LINES
) (
  input  logic         trap_i,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] mask_i,
  input  logic         ie_i,
  output logic         hit_o,
  output src_e         src_o
);
  logic [N-1:0] qual;

  for (genvar g = 0; g < N; g++) begin : g_qual
    assign qual[g] = line_i[g] & ~mask_i[g] & ie_i;
  end

  // scan upward so the highest line overrides; trap last
  always_comb begin
    hit_o = 1'b0;
    src_o = SRC_TRAP;
    for (int i = 0; i < N; i++) begin
      if (qual[i]) begin
        hit_o = 1'b1;
        src_o = src_e'(2'(i + 1));
      end
    end
    if (trap_i) begin
      hit_o = 1'b1;
      src_o = SRC_TRAP;
    end
  end
endmodule

// File: rtl/irq_state.sv
module irq_state #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         take_i,
  input  logic         ie_set_i,
  input  logic         ie_clr_i,
  input  logic         mask_load_i,
  input  logic [N-1:0] mask_i,
  input  logic         halt_req_i,
  output logic         ie_o,
  output logic [N-1:0] mask_o,
  output logic         halted_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_o     <= 1'b0;
      mask_o   <= '0;
      halted_o <= 1'b0;
    end else begin
      if (take_i || ie_clr_i) ie_o <= 1'b0;
      else if (ie_set_i)      ie_o <= 1'b1;
      if (mask_load_i) mask_o <= mask_i;
      if (take_i)          halted_o <= 1'b0;
      else if (halt_req_i) halted_o <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_unit_pkg::*;
#(
  parameter int VEC_W     = 16,
  parameter int SW_N      = 8,
  parameter int SW_STRIDE = 8,
  localparam int SW_IDX_W = $clog2(SW_N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 boundary_i,
  input  logic                 sw_req_i,
  input  logic [SW_IDX_W-1:0]  sw_num_i,
  input  logic                 ie_set_i,
  input  logic                 ie_clr_i,
  input  logic                 mask_load_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic                 halt_req_i,
  input  logic                 trap_i,
  input  logic [NUM_LINES-1:0] line_i,
  output logic                 take_o,
  output logic [VEC_W-1:0]     vector_o,
  output logic                 halted_o
);
  logic                 ie_w;
  logic [NUM_LINES-1:0] mask_w;
  logic                 hit_w;
  src_e                 src_w;
  logic                 accept;
  logic                 take_q;
  logic [VEC_W-1:0]     vector_q;

  irq_pick #(.N(NUM_LINES)) u_pick (
    .trap_i (trap_i),
    .line_i (line_i),
    .mask_i (mask_w),
    .ie_i   (ie_w),
    .hit_o  (hit_w),
    .src_o  (src_w)
  );

  // no decision during the acknowledge cycle keeps take a single pulse
  assign accept = (boundary_i || halted_o) && !take_q && hit_w;

  irq_state #(.N(NUM_LINES)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (accept),
    .ie_set_i    (ie_set_i),
    .ie_clr_i    (ie_clr_i),
    .mask_load_i (mask_load_i),
    .mask_i      (mask_i),
    .halt_req_i  (halt_req_i),
    .ie_o        (ie_w),
    .mask_o      (mask_w),
    .halted_o    (halted_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q   <= 1'b0;
      vector_q <= '0;
    end else begin
      take_q <= accept;
      if (accept)        vector_q <= VEC_W'(hw_vec(src_w));
      else if (sw_req_i) vector_q <= VEC_W'(sw_num_i) * VEC_W'(SW_STRIDE);
    end
  end

  assign take_o   = take_q;
  assign vector_o = vector_q;
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk #(
  parameter int VEC_W     = 16,
  parameter int SW_IDX_W  = 3,
  parameter int SW_STRIDE = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                boundary_i,
  input logic                sw_req_i,
  input logic [SW_IDX_W-1:0] sw_num_i,
  input logic                trap_i,
  input logic                take_o,
  input logic [VEC_W-1:0]    vector_o,
  input logic                halted_o,
  input logic                ie_q
);
  localparam logic [VEC_W-1:0] TRAP_V = VEC_W'(16'h0024);

  assert_sw_vector_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_o && $past(rst_ni && sw_req_i))
      |-> vector_o == VEC_W'($past(sw_num_i)) * VEC_W'(SW_STRIDE));

  assert_trap_taken_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && trap_i && boundary_i && !take_o) |-> (take_o && vector_o == TRAP_V));

  assert_masked_needs_ie_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vector_o != TRAP_V) |-> $past(ie_q));

  assert_ack_clears_ie_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !ie_q);

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  assert_at_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(boundary_i || halted_o));

  assert_halt_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !halted_o);

  assert_hw_over_sw_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(sw_req_i)) |-> vector_o[2:0] == 3'b100);
endmodule

bind irq_unit irq_unit_chk #(
  .VEC_W(VEC_W), .SW_IDX_W(SW_IDX_W), .SW_STRIDE(SW_STRIDE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boundary_i (boundary_i),
  .sw_req_i   (sw_req_i),
  .sw_num_i   (sw_num_i),
  .trap_i     (trap_i),
  .take_o     (take_o),
  .vector_o   (vector_o),
  .halted_o   (halted_o),
  .ie_q       (ie_w)
);

// File: tb/irq_unit_bench.sv
module irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary = 0, sw_req = 0, ie_set = 0, ie_clr = 0;
  logic        mask_load = 0, halt_req = 0, trap = 0;
  logic [2:0]  sw_num = 0, mask_v = 0, lines = 0;
  logic        take;
  logic [15:0] vector;
  logic        halted;

  int n_cmp = 0, n_bad = 0;
  logic        m_ie = 0, m_halt = 0, m_take = 0;
  logic [2:0]  m_mask = 0;
  logic [15:0] m_vec = 0;

  always #5 clk = ~clk;

  irq_unit u_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary), .sw_req_i(sw_req),
    .sw_num_i(sw_num), .ie_set_i(ie_set), .ie_clr_i(ie_clr),
    .mask_load_i(mask_load), .mask_i(mask_v), .halt_req_i(halt_req),
    .trap_i(trap), .line_i(lines), .take_o(take), .vector_o(vector),
    .halted_o(halted)
  );

  function automatic logic [16:0] pick(logic tr, logic [2:0] ln, logic ie, logic [2:0] mk);
    if (tr) return {1'b1, 16'h0024};
    if (ie && ln[2] && !mk[2]) return {1'b1, 16'h003C};
    if (ie && ln[1] && !mk[1]) return {1'b1, 16'h0034};
    if (ie && ln[0] && !mk[0]) return {1'b1, 16'h002C};
    return 17'd0;
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic b, logic swr, logic [2:0] swn, logic ies,
                      logic iec, logic ml, logic [2:0] mk, logic hr, logic tr,
                      logic [2:0] ln);
    logic [16:0] p;
    logic        acc;
    boundary = b; sw_req = swr; sw_num = swn; ie_set = ies; ie_clr = iec;
    mask_load = ml; mask_v = mk; halt_req = hr; trap = tr; lines = ln;
    p   = pick(tr, ln, m_ie, m_mask);
    acc = (b || m_halt) && !m_take && p[16];
    if (acc) m_vec = p[15:0];
    else if (swr) m_vec = {13'd0, swn} * 16'd8;
    if (acc || iec) m_ie = 1'b0; else if (ies) m_ie = 1'b1;
    if (ml) m_mask = mk;
    if (acc) m_halt = 1'b0; else if (hr) m_halt = 1'b1;
    m_take = acc;
    @(negedge clk);
    check(tag, "take", {15'd0, take}, {15'd0, m_take});
    check(tag, "vector", vector, m_vec);
    check(tag, "halted", {15'd0, halted}, {15'd0, m_halt});
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'b000);
  endtask

  task automatic arm(string tag);
    step(tag, 0, 0, 0, 1, 0, 0, 0, 0, 0, 3'b000);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = 17;
    void'($urandom(seed));
    repeat (2) @(negedge clk);
    // R6 reset state
    check("R6", "take", {15'd0, take}, 16'd0);
    check("R6", "vector", vector, 16'd0);
    check("R6", "halted", {15'd0, halted}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 all software restarts
    for (int n = 0; n < 8; n++) step("R1", 0, 1, 3'(n), 0, 0, 0, 0, 0, 0, 3'b000);
    // R6 reset left ie clear: pending line ignored
    step("R6", 1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b111);
    idle("R6");
    // R2 each line alone
    for (int k = 0; k < 3; k++) begin
      arm("R2");
      step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0, 3'(1 << k));
      idle("R2");
    end
    step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 1, 3'b000);
    idle("R2");
    // R3 priority
    arm("R3");
    step("R3", 1, 0, 0, 0, 0, 0, 0, 0, 1, 3'b111);
    idle("R3");
    arm("R3");
    step("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b111);
    idle("R3");
    arm("R3");
    step("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b011);
    idle("R3");
    // R7 masking
    step("R7", 0, 0, 0, 1, 0, 1, 3'b100, 0, 0, 3'b000);
    step("R7", 1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b101);
    idle("R7");
    step("R7", 0, 0, 0, 1, 0, 1, 3'b111, 0, 0, 3'b000);
    step("R7", 1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b111);
    step("R7", 0, 0, 0, 0, 0, 1, 3'b000, 0, 0, 3'b000);
    // R4 disabled lines ignored, trap passes
    step("R4", 0, 0, 0, 0, 1, 0, 0, 0, 0, 3'b000);
    step("R4", 1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b111);
    step("R4", 1, 0, 0, 0, 0, 0, 0, 0, 1, 3'b111);
    idle("R4");
    // R5 clear wins over set
    step("R5", 0, 0, 0, 1, 1, 0, 0, 0, 0, 3'b000);
    step("R5", 1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b001);
    // R6 ack clears ie even with set in same cycle
    arm("R6");
    step("R6", 1, 0, 0, 1, 0, 0, 0, 0, 0, 3'b100);
    step("R6", 1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b100);
    idle("R6");
    // R9 halt and release without boundary
    step("R9", 0, 0, 0, 1, 0, 0, 0, 1, 0, 3'b000);
    idle("R9");
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'b010);
    idle("R9");
    // R9 take beats halt request
    step("R9", 1, 0, 0, 0, 0, 0, 0, 1, 1, 3'b000);
    idle("R9");
    // R8 trap held across back-to-back boundaries
    step("R8", 1, 0, 0, 0, 0, 0, 0, 0, 1, 3'b000);
    step("R8", 1, 0, 0, 0, 0, 0, 0, 0, 1, 3'b000);
    step("R8", 1, 0, 0, 0, 0, 0, 0, 0, 1, 3'b000);
    // R8 no boundary, not halted: nothing taken
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'b000);
    idle("R8");
    // R10 hardware beats software restart
    step("R10", 1, 1, 3'd5, 0, 0, 0, 0, 0, 1, 3'b000);
    idle("R10");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      step("R3", ($urandom % 2) == 0, ($urandom % 7) == 0, 3'($urandom),
           ($urandom % 5) == 0, ($urandom % 9) == 0, ($urandom % 11) == 0,
           3'($urandom), ($urandom % 23) == 0, ($urandom % 17) == 0,
           {($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule